// File: doc/BRIEF.md
# Dependence-Steered In-Order Issue Queues

This block is the scheduling stage of an out-of-order core, but it has no wide issue window. It holds a small set of in-order queues. A steering stage takes one renamed instruction per cycle and puts it in a queue. An instruction that waits on a value is placed directly behind the instruction that produces that value, so each queue ends up holding one dependence chain.

A producer map is indexed by logical register. Each entry records which queue holds the newest pending writer of that register, and that writer's physical tag. A ready bit for each physical register records whether its value exists. Only the instruction at the head of each queue reads the ready bits. Every cycle, heads whose two sources are ready are issued, at most `ISSUE_W` of them. Completion notices arrive by physical register and set the ready bits.

The input is a valid/ready stream. When `in_valid` is high and `in_ready` is low, the instruction is stalled. The source must then hold the instruction and every field stable until a cycle in which both are high, and that cycle is the handshake. `steer_stall` makes this condition visible as a plain pin. `in_ready` is combinational from the stored state and the offered source fields, and it never depends on `in_valid`. The issue outputs are valid-only because the execution side always accepts them. Every instruction names two sources; an instruction with one operand repeats it.

Top module: `dep_issue_queues`

## Requirements
- R1: After reset every queue is empty and no slot is issuing. `in_ready` is high and `steer_stall` is low. Every physical register is marked ready.
- R2: If both source ready bits are set when an instruction is accepted, it goes to the lowest-numbered empty queue. If the queue it lands in has no older entry, it issues in the cycle that follows the accepting edge.
- R3: An instruction may have exactly one unready source whose recorded producer is the newest entry of a queue that is not full. That instruction is appended to that queue.
- R4: If the recorded producer has a younger entry behind it, or if its queue holds `FIFO_DEPTH` entries, the instruction goes to the lowest-numbered empty queue instead.
- R5: When both sources are unready, the producer of source 1 is tried first under the R3 rule. If that fails, the producer of source 2 is tried. If both fail, the instruction goes to an empty queue.
- R6: A source can be unready while its producer map entry is clear, because its producer has already issued. Such a source cannot be joined, so the instruction goes to an empty queue.
- R7: `in_ready` is low only when no join target exists and no queue is empty. While it is low, `steer_stall` equals `in_valid`. A held instruction is accepted once a queue frees, and its fields are unchanged.
- R8: Only queue heads are considered for issue, and a head issues only when both of its source ready bits are set. Entries behind a blocked head never issue ahead of it.
- R9: Accepting an instruction clears the ready bit of its destination. A completion sets the ready bit of its register. A head waiting on that register issues in the cycle that follows the completion edge.
- R10: At most `ISSUE_W` heads issue per cycle. Heads are chosen in increasing queue number and placed in slots 0 upward.
- R11: A producer map entry is cleared when its producer issues. It is overwritten when a newer writer of the same logical register is accepted, and later consumers then follow the newer writer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Renamed instruction offered |
| in_ready | output | 1 | Steering can place the offered instruction |
| in_src1_lreg | input | LREG_W | Logical register of source 1 |
| in_src1_preg | input | PREG_W | Physical register of source 1 |
| in_src2_lreg | input | LREG_W | Logical register of source 2 |
| in_src2_preg | input | PREG_W | Physical register of source 2 |
| in_dst_lreg | input | LREG_W | Logical destination register |
| in_dst_preg | input | PREG_W | Physical destination register |
| steer_stall | output | 1 | Offered instruction cannot be placed this cycle |
| cmpl_valid | input | 1 | A result has been produced |
| cmpl_preg | input | PREG_W | Physical register that was produced |
| iss_valid | output | ISSUE_W | Issue slot carries an instruction |
| iss_fifo | output | ISSUE_W*FIFO_IDX_W | Queue each slot was taken from |
| iss_src1_preg | output | ISSUE_W*PREG_W | Source 1 tag per slot |
| iss_src2_preg | output | ISSUE_W*PREG_W | Source 2 tag per slot |
| iss_dst_preg | output | ISSUE_W*PREG_W | Destination tag per slot |

## Verification
Every result is due one clock edge after its cause. An instruction that is ready on arrival appears on an issue slot in the cycle after the edge that accepted it. A waiting head appears in the cycle after the edge that carried its completion. A queue emptied by an issue can accept a stalled instruction one edge after that issue. The bench reads an edge counter and samples the issue slots on falling edges, so every check can compare the exact edge on which an instruction issued, not only the queue it came from.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  // Outcome of the steering decision for one offered instruction.
  typedef enum logic [1:0] {
    STEER_FRESH   = 2'd0,
    STEER_JOIN_S1 = 2'd1,
    STEER_JOIN_S2 = 2'd2,
    STEER_BLOCKED = 2'd3
  } steer_e;
endpackage

// File: rtl/dsq_fifo.sv
module dsq_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         empty,
  output logic         full,
  output logic [W-1:0] head_data,
  output logic [W-1:0] tail_data
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = IDX_W + 1;

  logic [W-1:0]     mem [DEPTH];
  logic [IDX_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign empty     = (count == '0);
  assign full      = (count == CNT_W'(DEPTH));
  assign head_data = mem[rd_ptr];
  assign tail_data = mem[wr_ptr - IDX_W'(1)];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == IDX_W'(DEPTH - 1)) ? '0 : wr_ptr + IDX_W'(1);
      if (pop)  rd_ptr <= (rd_ptr == IDX_W'(DEPTH - 1)) ? '0 : rd_ptr + IDX_W'(1);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // R7: steering must never push into a full queue
  a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R8: only a present head can be issued
  a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/dsq_steer.sv
module dsq_steer
  import dsq_pkg::*;
#(
  parameter int NUM_FIFO   = 8,
  parameter int LREG_W     = 5,
  parameter int FIFO_IDX_W = 3
) (
  input  logic [LREG_W-1:0]          src1_lreg,
  input  logic [LREG_W-1:0]          src2_lreg,
  input  logic                       src1_rdy,
  input  logic                       src2_rdy,
  input  logic                       tbl1_vld,
  input  logic                       tbl2_vld,
  input  logic [FIFO_IDX_W-1:0]      tbl1_fifo,
  input  logic [FIFO_IDX_W-1:0]      tbl2_fifo,
  input  logic [NUM_FIFO-1:0]        fifo_empty,
  input  logic [NUM_FIFO-1:0]        fifo_full,
  input  logic [NUM_FIFO*LREG_W-1:0] tail_lreg,
  output steer_e                     kind,
  output logic [FIFO_IDX_W-1:0]      tgt
);
  logic                  join1, join2, free_ok;
  logic [FIFO_IDX_W-1:0] free_idx;

  // A producer is joinable when it is the newest entry of a non-full queue.
  always_comb begin
    join1 = !src1_rdy && tbl1_vld && !fifo_empty[tbl1_fifo] && !fifo_full[tbl1_fifo] &&
            (tail_lreg[tbl1_fifo*LREG_W +: LREG_W] == src1_lreg);
    join2 = !src2_rdy && tbl2_vld && !fifo_empty[tbl2_fifo] && !fifo_full[tbl2_fifo] &&
            (tail_lreg[tbl2_fifo*LREG_W +: LREG_W] == src2_lreg);
  end

  always_comb begin
    free_ok  = 1'b0;
    free_idx = '0;
    for (int f = NUM_FIFO - 1; f >= 0; f--) begin
      if (fifo_empty[f]) begin
        free_ok  = 1'b1;
        free_idx = FIFO_IDX_W'(f);
      end
    end
  end

  always_comb begin
    if (join1) begin
      kind = STEER_JOIN_S1;
      tgt  = tbl1_fifo;
    end else if (join2) begin
      kind = STEER_JOIN_S2;
      tgt  = tbl2_fifo;
    end else if (free_ok) begin
      kind = STEER_FRESH;
      tgt  = free_idx;
    end else begin
      kind = STEER_BLOCKED;
      tgt  = '0;
    end
  end
endmodule

// File: rtl/dsq_select.sv
module dsq_select #(
  parameter int NUM_FIFO   = 8,
  parameter int ISSUE_W    = 2,
  parameter int FIFO_IDX_W = 3
) (
  input  logic [NUM_FIFO-1:0]           head_rdy,
  output logic [NUM_FIFO-1:0]           grant,
  output logic [ISSUE_W-1:0]            slot_vld,
  output logic [ISSUE_W*FIFO_IDX_W-1:0] slot_fifo
);
  // Lowest queue number first, filling slots in order.
  always_comb begin
    int n;
    n         = 0;
    grant     = '0;
    slot_vld  = '0;
    slot_fifo = '0;
    for (int f = 0; f < NUM_FIFO; f++) begin
      if (head_rdy[f] && (n < ISSUE_W)) begin
        grant[f]                                 = 1'b1;
        slot_vld[n]                              = 1'b1;
        slot_fifo[n*FIFO_IDX_W +: FIFO_IDX_W]    = FIFO_IDX_W'(f);
        n++;
      end
    end
  end
endmodule

// File: rtl/dep_issue_queues.sv
module dep_issue_queues
  import dsq_pkg::*;
#(
  parameter int NUM_FIFO   = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int NUM_LREG   = 32,
  parameter int NUM_PREG   = 64,
  parameter int ISSUE_W    = 2,
  localparam int LREG_W     = $clog2(NUM_LREG),
  localparam int PREG_W     = $clog2(NUM_PREG),
  localparam int FIFO_IDX_W = $clog2(NUM_FIFO)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [LREG_W-1:0]             in_src1_lreg,
  input  logic [PREG_W-1:0]             in_src1_preg,
  input  logic [LREG_W-1:0]             in_src2_lreg,
  input  logic [PREG_W-1:0]             in_src2_preg,
  input  logic [LREG_W-1:0]             in_dst_lreg,
  input  logic [PREG_W-1:0]             in_dst_preg,
  output logic                          steer_stall,
  input  logic                          cmpl_valid,
  input  logic [PREG_W-1:0]             cmpl_preg,
  output logic [ISSUE_W-1:0]            iss_valid,
  output logic [ISSUE_W*FIFO_IDX_W-1:0] iss_fifo,
  output logic [ISSUE_W*PREG_W-1:0]     iss_src1_preg,
  output logic [ISSUE_W*PREG_W-1:0]     iss_src2_preg,
  output logic [ISSUE_W*PREG_W-1:0]     iss_dst_preg
);
  // Entry layout: {dst_lreg, dst_preg, src2_preg, src1_preg}
  localparam int ENT_W = LREG_W + 3 * PREG_W;

  logic [NUM_PREG-1:0]   ready_q;
  logic [NUM_LREG-1:0]   tbl_vld;
  logic [FIFO_IDX_W-1:0] tbl_fifo [NUM_LREG];
  logic [PREG_W-1:0]     tbl_preg [NUM_LREG];

  logic [NUM_FIFO-1:0]        fifo_empty, fifo_full, fifo_push, head_rdy, grant;
  logic [ENT_W-1:0]           head_data [NUM_FIFO];
  logic [NUM_FIFO*LREG_W-1:0] tail_lreg;
  logic [ENT_W-1:0]           in_entry;
  logic [LREG_W-1:0]          iss_dst_lreg [ISSUE_W];

  steer_e                kind;
  logic [FIFO_IDX_W-1:0] tgt;
  logic                  accept;

  assign in_entry    = {in_dst_lreg, in_dst_preg, in_src2_preg, in_src1_preg};
  assign in_ready    = (kind != STEER_BLOCKED);
  assign accept      = in_valid && in_ready;
  assign steer_stall = in_valid && !in_ready;

  dsq_steer #(
    .NUM_FIFO(NUM_FIFO), .LREG_W(LREG_W), .FIFO_IDX_W(FIFO_IDX_W)
  ) steer_i (
    .src1_lreg (in_src1_lreg),
    .src2_lreg (in_src2_lreg),
    .src1_rdy  (ready_q[in_src1_preg]),
    .src2_rdy  (ready_q[in_src2_preg]),
    .tbl1_vld  (tbl_vld[in_src1_lreg]),
    .tbl2_vld  (tbl_vld[in_src2_lreg]),
    .tbl1_fifo (tbl_fifo[in_src1_lreg]),
    .tbl2_fifo (tbl_fifo[in_src2_lreg]),
    .fifo_empty(fifo_empty),
    .fifo_full (fifo_full),
    .tail_lreg (tail_lreg),
    .kind      (kind),
    .tgt       (tgt)
  );

  for (genvar f = 0; f < NUM_FIFO; f++) begin : g_queue
    logic [ENT_W-1:0] tail_data;
    logic [PREG_W-1:0] h_src1, h_src2;

    assign fifo_push[f] = accept && (tgt == FIFO_IDX_W'(f));

    dsq_fifo #(.DEPTH(FIFO_DEPTH), .W(ENT_W)) q_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (fifo_push[f]),
      .push_data(in_entry),
      .pop      (grant[f]),
      .empty    (fifo_empty[f]),
      .full     (fifo_full[f]),
      .head_data(head_data[f]),
      .tail_data(tail_data)
    );

    assign tail_lreg[f*LREG_W +: LREG_W] = tail_data[ENT_W-1 -: LREG_W];
    assign h_src1      = head_data[f][PREG_W-1:0];
    assign h_src2      = head_data[f][2*PREG_W-1:PREG_W];
    // Wakeup looks at the head only.
    assign head_rdy[f] = !fifo_empty[f] && ready_q[h_src1] && ready_q[h_src2];
  end

  dsq_select #(
    .NUM_FIFO(NUM_FIFO), .ISSUE_W(ISSUE_W), .FIFO_IDX_W(FIFO_IDX_W)
  ) sel_i (
    .head_rdy (head_rdy),
    .grant    (grant),
    .slot_vld (iss_valid),
    .slot_fifo(iss_fifo)
  );

  always_comb begin
    for (int s = 0; s < ISSUE_W; s++) begin
      logic [ENT_W-1:0] e;
      e = head_data[iss_fifo[s*FIFO_IDX_W +: FIFO_IDX_W]];
      iss_src1_preg[s*PREG_W +: PREG_W] = e[PREG_W-1:0];
      iss_src2_preg[s*PREG_W +: PREG_W] = e[2*PREG_W-1:PREG_W];
      iss_dst_preg[s*PREG_W +: PREG_W]  = e[3*PREG_W-1:2*PREG_W];
      iss_dst_lreg[s]                   = e[ENT_W-1 -: LREG_W];
    end
  end

  // Ready bits: completion sets, acceptance of a new writer clears (clear wins).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= '1;
    end else begin
      if (cmpl_valid) ready_q[cmpl_preg] <= 1'b1;
      if (accept)     ready_q[in_dst_preg] <= 1'b0;
    end
  end

  // Producer map: cleared when its producer issues, overwritten by a newer writer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_vld <= '0;
    end else begin
      for (int s = 0; s < ISSUE_W; s++) begin
        if (iss_valid[s] && tbl_vld[iss_dst_lreg[s]] &&
            (tbl_preg[iss_dst_lreg[s]] == iss_dst_preg[s*PREG_W +: PREG_W]))
          tbl_vld[iss_dst_lreg[s]] <= 1'b0;
      end
      if (accept) tbl_vld[in_dst_lreg] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      tbl_fifo[in_dst_lreg] <= tgt;
      tbl_preg[in_dst_lreg] <= in_dst_preg;
    end
  end

  // R7: stalling only happens with every queue occupied
  a_r7_stall_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> (fifo_empty == '0));
  // R2: an instruction with both sources ready lands in an empty queue
  a_r2_ready_goes_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ready_q[in_src1_preg] && ready_q[in_src2_preg]) |-> ((fifo_push & fifo_empty) != '0));
  // R9: a completion leaves its register ready on the next cycle
  a_r9_cmpl_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && !(accept && (in_dst_preg == cmpl_preg))) |=> ready_q[$past(cmpl_preg)]);
  // R10: issue width bound
  a_r10_issue_width: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) <= ISSUE_W);

  for (genvar l = 0; l < NUM_LREG; l++) begin : g_tbl_chk
    // R11: a recorded producer is still held in the queue it points at
    a_r11_map_points_live: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_vld[l] |-> !fifo_empty[tbl_fifo[l]]);
  end
endmodule

// File: tb/dep_issue_queues_tb.sv
`timescale 1ns/1ps
module dep_issue_queues_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_src1_lreg = '0, in_src2_lreg = '0, in_dst_lreg = '0;
  logic [5:0]  in_src1_preg = '0, in_src2_preg = '0, in_dst_preg = '0;
  logic        steer_stall;
  logic        cmpl_valid = 1'b0;
  logic [5:0]  cmpl_preg = '0;
  logic [1:0]  iss_valid;
  logic [5:0]  iss_fifo;
  logic [11:0] iss_src1_preg, iss_src2_preg, iss_dst_preg;

  int checks = 0;
  int fails  = 0;
  int edge_cnt = 0;
  int max_per_cyc = 0;
  bit issued    [64];
  int iss_q_of  [64];
  int iss_cyc_of[64];

  always #4 clk = ~clk;   // 125 MHz

  dep_issue_queues dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_src1_lreg(in_src1_lreg), .in_src1_preg(in_src1_preg),
    .in_src2_lreg(in_src2_lreg), .in_src2_preg(in_src2_preg),
    .in_dst_lreg(in_dst_lreg), .in_dst_preg(in_dst_preg),
    .steer_stall(steer_stall),
    .cmpl_valid(cmpl_valid), .cmpl_preg(cmpl_preg),
    .iss_valid(iss_valid), .iss_fifo(iss_fifo),
    .iss_src1_preg(iss_src1_preg), .iss_src2_preg(iss_src2_preg),
    .iss_dst_preg(iss_dst_preg)
  );

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  // Issue monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 64; p++) begin
        issued[p] = 1'b0; iss_q_of[p] = -1; iss_cyc_of[p] = -1;
      end
      max_per_cyc = 0;
    end else begin
      int n;
      n = 0;
      for (int s = 0; s < 2; s++) begin
        if (iss_valid[s]) begin
          int p;
          p = int'(iss_dst_preg[s*6 +: 6]);
          issued[p] = 1'b1;
          iss_q_of[p] = int'(iss_fifo[s*3 +: 3]);
          iss_cyc_of[p] = edge_cnt;
          n++;
        end
      end
      if (n > max_per_cyc) max_per_cyc = n;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; cmpl_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic drive(input int s1l, input int s1p, input int s2l, input int s2p,
                       input int dl, input int dp);
    in_src1_lreg = 5'(s1l); in_src1_preg = 6'(s1p);
    in_src2_lreg = 5'(s2l); in_src2_preg = 6'(s2p);
    in_dst_lreg  = 5'(dl);  in_dst_preg  = 6'(dp);
    in_valid = 1'b1;
    #1;
  endtask

  // Offer at a falling edge, hold until accepted; returns the accepting edge number.
  task automatic dispatch(input int s1l, input int s1p, input int s2l, input int s2p,
                          input int dl, input int dp, output int acc);
    drive(s1l, s1p, s2l, s2p, dl, dp);
    while (!in_ready) begin @(posedge clk); @(negedge clk); #1; end
    @(negedge clk);
    acc = edge_cnt;
    in_valid = 1'b0;
  endtask

  task automatic complete(input int p, output int e);
    cmpl_valid = 1'b1; cmpl_preg = 6'(p);
    @(negedge clk);
    e = edge_cnt;
    cmpl_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_iss(input int p, input int q, input int cyc, input string tag);
    check(issued[p], {tag, " issued"}, int'(issued[p]), 1);
    check(iss_q_of[p] == q, {tag, " queue"}, iss_q_of[p], q);
    check(iss_cyc_of[p] == cyc, {tag, " issue edge"}, iss_cyc_of[p], cyc);
  endtask

  task automatic t_reset();
    do_reset();
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    check(steer_stall == 1'b0, "R1 steer_stall", int'(steer_stall), 0);
    check(iss_valid == 2'b00, "R1 iss_valid", int'(iss_valid), 0);
  endtask

  task automatic t_ready_on_arrival();
    int a;
    do_reset();
    dispatch(1, 1, 2, 2, 1, 10, a);      // all sources ready after reset (R1)
    idle(1);
    expect_iss(10, 0, a, "R2 ready instr");
  endtask

  task automatic t_chain();
    int a, e1, e2;
    do_reset();
    dispatch(1, 1, 2, 2, 9, 10, a); idle(2);    // producer issues, map cleared (R11)
    dispatch(9, 10, 9, 10, 2, 11, a);           // R6: no producer recorded -> fresh q0
    dispatch(2, 11, 2, 11, 3, 12, a);           // R3: joins q0 behind p11
    dispatch(1, 1, 2, 2, 4, 13, a);             // R2: ready -> q1
    idle(2);
    check(!issued[11], "R8 blocked head held", int'(issued[11]), 0);
    expect_iss(13, 1, a, "R2 second queue");
    complete(10, e1); idle(1);
    expect_iss(11, 0, e1, "R9 wake after completion");
    check(!issued[12], "R8 follower waits", int'(issued[12]), 0);
    complete(11, e2); idle(1);
    expect_iss(12, 0, e2, "R3 joined chain");
  endtask

  task automatic t_not_tail();
    int a, e1, e2;
    do_reset();
    dispatch(1, 1, 2, 2, 1, 10, a); idle(2);
    dispatch(1, 10, 1, 10, 2, 11, a);           // q0
    dispatch(2, 11, 2, 11, 3, 12, a);           // joins q0
    dispatch(2, 11, 2, 11, 4, 13, a);           // R4: producer has a follower -> q1
    complete(10, e1); idle(1);
    expect_iss(11, 0, e1, "R9 head wake");
    complete(11, e2); idle(1);
    expect_iss(12, 0, e2, "R10 slot order q0");
    expect_iss(13, 1, e2, "R4 not-tail to fresh");
  endtask

  task automatic t_two_outstanding();
    int a, e1, e2, e3;
    do_reset();
    dispatch(1, 1, 2, 2, 9, 10, a); idle(2);
    dispatch(9, 10, 9, 10, 1, 20, a);           // q0
    dispatch(9, 10, 9, 10, 2, 21, a);           // q1
    dispatch(1, 20, 2, 21, 5, 22, a);           // R5: source 1 producer first -> q0
    dispatch(1, 20, 2, 21, 6, 23, a);           // R5: source 1 not at tail, source 2 is -> q1
    complete(10, e1); idle(1);
    expect_iss(20, 0, e1, "R10 dual issue q0");
    expect_iss(21, 1, e1, "R10 dual issue q1");
    complete(20, e2);
    complete(21, e3); idle(1);
    check(iss_cyc_of[22] == e3, "R8 waits for both sources", iss_cyc_of[22], e3);
    expect_iss(22, 0, e3, "R5 source 1 preferred");
    expect_iss(23, 1, e3, "R5 source 2 fallback");
  endtask

  task automatic t_stall_width();
    int a, e;
    do_reset();
    dispatch(1, 1, 2, 2, 9, 10, a); idle(2);
    for (int k = 0; k < 8; k++) dispatch(9, 10, 9, 10, 10 + k, 30 + k, a);
    drive(9, 10, 9, 10, 20, 40);
    check(in_ready == 1'b0, "R7 blocked ready", int'(in_ready), 0);
    check(steer_stall == 1'b1, "R7 stall pin", int'(steer_stall), 1);
    idle(3); #1;
    check(steer_stall == 1'b1, "R7 stall held", int'(steer_stall), 1);
    complete(10, e); #1;
    check(iss_valid == 2'b11, "R10 two slots", int'(iss_valid), 3);
    check(iss_fifo[2:0] == 3'd0 && iss_fifo[5:3] == 3'd1, "R10 lowest first",
          int'(iss_fifo), 8);
    check(in_ready == 1'b0, "R7 still blocked", int'(in_ready), 0);
    idle(1); #1;
    check(in_ready == 1'b1, "R7 queue freed", int'(in_ready), 1);
    idle(1);
    in_valid = 1'b0;
    idle(4);
    expect_iss(40, 0, e + 2, "R7 held instr accepted");
    expect_iss(37, 7, e + 4, "R10 last queue");
    check(max_per_cyc <= 2, "R10 width bound", max_per_cyc, 2);
  endtask

  task automatic t_overwrite();
    int a, e1, e2;
    do_reset();
    dispatch(1, 1, 2, 2, 9, 10, a); idle(2);
    dispatch(9, 10, 9, 10, 1, 20, a);           // q0 writes l1
    dispatch(9, 10, 9, 10, 1, 21, a);           // q1 newer writer of l1
    dispatch(1, 21, 1, 21, 3, 22, a);           // R11: follows newest writer -> q1
    complete(10, e1);
    complete(21, e2); idle(1);
    expect_iss(22, 1, e2, "R11 newer writer");
  endtask

  task automatic t_full_queue();
    int a, e;
    do_reset();
    dispatch(1, 1, 2, 2, 9, 10, a); idle(2);
    dispatch(9, 10, 9, 10, 1, 40, a);
    for (int k = 1; k < 8; k++) dispatch(k, 39 + k, k, 39 + k, k + 1, 40 + k, a);
    dispatch(8, 47, 8, 47, 20, 50, a);          // R4: producer at tail of full q0 -> q1
    complete(47, e); idle(1);
    expect_iss(50, 1, e, "R4 full queue");
    check(!issued[41], "R8 in-order chain", int'(issued[41]), 0);
    check(!issued[47], "R8 tail behind blocked head", int'(issued[47]), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_ready_on_arrival();
    t_chain();
    t_not_tail();
    t_two_outstanding();
    t_stall_width();
    t_overwrite();
    t_full_queue();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule